// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Receiver

This block is a byte-wide serial receiver that acts as bus master: it generates the transfer clock itself and samples a data line from an attached slave device. Software configures it through a small register bank on a simple internal bus. With both enable bits set and no fault pending, a write of any value to the transmit-buffer address starts one byte. The block then toggles the transfer clock from a prescaled system clock and samples the receive line on each rising clock edge. After the eighth bit it copies the byte into the receive buffer, sets a completion flag and pulses a receive interrupt request.

The transfer clock rests high. A clock-delay option adds half a bit period of high level before the first falling edge. Each byte needs its own start write; the block never runs on into a second byte by itself. The slave-select input serves as a fault detector. If it is low while reception is enabled, a fault flag is set and any transfer in progress stops at once.

The controller is a four-state machine. IDLE holds the clock high and waits for a start. LEAD holds the clock high for half a bit period and is entered from IDLE only when the clock delay is on. LOW drives the clock low for half a period. HIGH drives it high for half a period. The transitions are START_DLY (IDLE to LEAD), START (IDLE to LOW), LEAD_END (LEAD to LOW), RISE (LOW to HIGH, sampling one bit), LAST_RISE (LOW to IDLE on the eighth bit, completing the byte), FALL (HIGH to LOW) and ABORT (any state to IDLE on a fault).

Top module: `ssr_master_rx`

Register map. Address 0 is the control register: bit 0 is the receive enable, bit 1 the transmit enable, bits 3:2 the clock select, and bit 4 the clock delay. Bits 7:5 are stored and read back. Address 1 is the transmit buffer; a write starts a byte and a read returns 0. Address 2 is the receive buffer, read only. Address 3 is status: bit 0 done, bit 1 overrun, bit 2 fault, bit 3 busy.

## Requirements
- R1: After reset the transfer clock output is high, the interrupt output is low, and both the status register and the receive buffer read 0.
- R2: A byte starts only on a write to address 1 while control bits 0 and 1 are both 1 and the fault flag is 0. Any other start write leaves busy (status bit 3) at 0 and the clock high.
- R3: Each half period of the transfer clock lasts 1, 8 or 32 system clock cycles for clock-select values 0, 1 and 2, and 32 cycles for value 3. Without delay, the interrupt rises 15 half periods after the start write.
- R4: With control bit 4 set, one extra high half period precedes the first falling edge, so the interrupt rises 16 half periods after the start write.
- R5: The receive line is sampled on each rising clock edge and shifted right, with each new bit entering the top bit. The first bit received therefore ends up in bit 0 of the receive buffer.
- R6: On the eighth rising edge the byte moves into the receive buffer, done is set, and the interrupt output is high for exactly one cycle. Exactly eight falling clock edges occur per byte, and the clock stays high afterwards.
- R7: A read of address 2 clears done. If the read falls in the same cycle as a byte completion, done stays 1, overrun stays 0, and the read returns the previous byte.
- R8: If a byte completes while done is still 1, overrun (status bit 1) is set and the buffer takes the new byte. Writing 1 to status bit 1 clears overrun.
- R9: While control bit 0 is 1, a low slave-select input sets fault (status bit 2) on the next edge and aborts any transfer without an interrupt. Starts are refused while fault is 1, and writing 1 to status bit 2 clears it.
- R10: A start write while a byte is in progress is ignored, and the byte completes with its normal timing and data.
- R11: After a byte completes the block stays idle until the next start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| sclk_o | output | 1 | Transfer clock to the slave, idles high |
| rxd_i | input | 1 | Serial receive data |
| ssel_n_i | input | 1 | Slave-select fault input, must stay high |
| rx_irq_o | output | 1 | Receive interrupt request, one-cycle pulse |

## Verification
Byte completion and a software read of the receive buffer can fall on the same clock edge, and both change the done flag. The bench leaves done set from an earlier byte and starts a fast transfer. Since the completion edge is known from the timing rule, it places the read strobe on exactly that edge. It then requires that the read returned the old byte, that done is still 1, and that overrun is still 0. It also runs the opposite case, a completion with no read, which must raise overrun.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } ssr_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TX   = 2'd1;
    localparam logic [1:0] ADDR_RX   = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CTL_RXEN  = 0;
    localparam int CTL_TXEN  = 1;
    localparam int CTL_SEL_L = 2;
    localparam int CTL_DLY   = 4;

    localparam int STS_DONE  = 0;
    localparam int STS_OVR   = 1;
    localparam int STS_FAULT = 2;
    localparam int STS_BUSY  = 3;

endpackage

// File: rtl/ssr_prescaler.sv
module ssr_prescaler #(
    parameter int DIV0 = 1,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAXDIV = (DIV0 > DIV1) ? ((DIV0 > DIV2) ? DIV0 : DIV2)
                                          : ((DIV1 > DIV2) ? DIV1 : DIV2);
    localparam int CW = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        unique case (sel)
            2'd0:    limit = CW'(DIV0 - 1);
            2'd1:    limit = CW'(DIV1 - 1);
            default: limit = CW'(DIV2 - 1);
        endcase
    end

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_next,
    output logic         last
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  data_q;
    logic [BW-1:0] cnt_q;

    assign word_next = {din, data_q[W-1:1]};
    assign last      = (cnt_q == BW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
        end else if (shift_en) begin
            data_q <= word_next;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ssr_regs.sv
module ssr_regs
    import ssr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic         complete,
    input  logic         fault_set,
    input  logic         busy,
    input  logic [W-1:0] word,
    output logic [7:0]   ctrl,
    output logic         start_req,
    output logic         done,
    output logic         fault,
    output logic         irq
);
    logic [W-1:0] rxbuf_q;
    logic         ovr_q;
    logic         rd_rx;
    logic         wr_stat;

    assign rd_rx     = bus_rd && (bus_addr == ADDR_RX);
    assign wr_stat   = bus_wr && (bus_addr == ADDR_STAT);
    assign start_req = bus_wr && (bus_addr == ADDR_TX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            rxbuf_q <= '0;
            done    <= 1'b0;
            ovr_q   <= 1'b0;
            fault   <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (bus_wr && (bus_addr == ADDR_CTRL)) begin
                ctrl <= bus_wdata;
            end
            irq <= complete;
            if (complete) begin
                rxbuf_q <= word;
            end
            if (complete) begin
                done <= 1'b1;
            end else if (rd_rx) begin
                done <= 1'b0;
            end
            if (complete && done && !rd_rx) begin
                ovr_q <= 1'b1;
            end else if (wr_stat && bus_wdata[STS_OVR]) begin
                ovr_q <= 1'b0;
            end
            if (fault_set) begin
                fault <= 1'b1;
            end else if (wr_stat && bus_wdata[STS_FAULT]) begin
                fault <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_TX:   bus_rdata = '0;
            ADDR_RX:   bus_rdata = 8'(rxbuf_q);
            ADDR_STAT: begin
                bus_rdata[STS_DONE]  = done;
                bus_rdata[STS_OVR]   = ovr_q;
                bus_rdata[STS_FAULT] = fault;
                bus_rdata[STS_BUSY]  = busy;
            end
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ssr_master_rx.sv
module ssr_master_rx
    import ssr_pkg::*;
#(
    parameter int DIV0 = 1,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32,
    parameter int W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sclk_o,
    input  logic       rxd_i,
    input  logic       ssel_n_i,
    output logic       rx_irq_o
);
    ssr_state_e   state_q, state_d;
    logic [7:0]   ctrl;
    logic         start_req, done, fault, irq;
    logic         tick, last, start, fault_set, rise, complete, busy;
    logic [W-1:0] word_next;

    assign fault_set = ctrl[CTL_RXEN] && !ssel_n_i;
    assign start     = start_req && ctrl[CTL_RXEN] && ctrl[CTL_TXEN] && !fault
                       && !fault_set && (state_q == ST_IDLE);
    assign rise      = (state_q == ST_LOW) && tick && !fault_set;
    assign complete  = rise && last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (fault_set) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_d = ctrl[CTL_DLY] ? ST_LEAD : ST_LOW;
                ST_LEAD: if (tick)  state_d = ST_LOW;
                ST_LOW:  if (tick)  state_d = last ? ST_IDLE : ST_HIGH;
                ST_HIGH: if (tick)  state_d = ST_LOW;
                default:            state_d = ST_IDLE;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin sclk_o = 1'b1; busy = 1'b0; end
            ST_LOW:  begin sclk_o = 1'b0; busy = 1'b1; end
            default: begin sclk_o = 1'b1; busy = 1'b1; end
        endcase
    end

    assign rx_irq_o = irq;

    ssr_prescaler #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .run   (busy),
        .sel   (ctrl[CTL_SEL_L +: 2]),
        .tick  (tick)
    );

    ssr_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .shift_en  (rise),
        .din       (rxd_i),
        .word_next (word_next),
        .last      (last)
    );

    ssr_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .complete  (complete),
        .fault_set (fault_set),
        .busy      (busy),
        .word      (word_next),
        .ctrl      (ctrl),
        .start_req (start_req),
        .done      (done),
        .fault     (fault),
        .irq       (irq)
    );

endmodule

// File: rtl/ssr_master_rx_chk.sv
module ssr_master_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       ssel_n_i,
    input logic       sclk_o,
    input logic       rx_irq_o,
    input logic       busy,
    input logic       done,
    input logic       fault,
    input logic [7:0] ctrl
);
    // R6
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |=> !rx_irq_o);

    // R6
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> done);

    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(bus_rd && bus_addr == 2'd2)) |=> done);

    // R9
    fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && !ssel_n_i) |=> (fault && !busy && sclk_o));

    // R11
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o);

    // R2
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr == 2'd1 && !(ctrl[0] && ctrl[1])) |=> !busy);

endmodule

bind ssr_master_rx ssr_master_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .ssel_n_i (ssel_n_i),
    .sclk_o   (sclk_o),
    .rx_irq_o (rx_irq_o),
    .busy     (busy),
    .done     (done),
    .fault    (fault),
    .ctrl     (ctrl)
);

// File: tb/sim_ssr_master_rx.sv
`timescale 1ns/1ps
module sim_ssr_master_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk_o, rxd_i, ssel_n_i, rx_irq_o;
    int         n_chk = 0;
    int         n_bad = 0;
    int         irq_seen = 0;

    initial rxd_i = 1'b0;
    initial ssel_n_i = 1'b1;

    always #2.5 clk = ~clk;

    ssr_master_rx u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .rxd_i(rxd_i), .ssel_n_i(ssel_n_i), .rx_irq_o(rx_irq_o)
    );

    // {clock select, delay, data}
    localparam logic [10:0] VEC [6] = '{
        {2'd0, 1'b0, 8'hA5}, {2'd0, 1'b1, 8'h3C}, {2'd1, 1'b0, 8'h81},
        {2'd1, 1'b1, 8'h7E}, {2'd2, 1'b0, 8'hC3}, {2'd3, 1'b1, 8'h5A}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int divof(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 8 : 32;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // poke: 0 none, 1 read receive buffer, 2 start write
    task automatic xfer(input logic [1:0] sel, input logic dly, input logic [7:0] data,
                        input int poke_at, input int poke,
                        output int lat, output int falls, output logic [7:0] pv);
        logic prev;
        int   j;
        wr(2'd0, {3'b000, dly, sel, 2'b11});
        wr(2'd1, 8'h00);
        prev = 1'b1; falls = 0; lat = -1; j = 0; pv = '0;
        while (j < 3000) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
            if (j == poke_at && poke == 1) begin
                bus_addr = 2'd2; bus_rd = 1'b1;
                #1 pv = bus_rdata;
            end else if (j == poke_at && poke == 2) begin
                bus_addr = 2'd1; bus_wr = 1'b1;
            end
            if (rx_irq_o) begin
                lat = j;
                break;
            end
            if (prev && !sclk_o) begin
                if (falls < 8) rxd_i = data[falls];
                falls++;
            end
            prev = sclk_o;
            j++;
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R6 irq one cycle", rx_irq_o, 0);
        repeat (40) begin
            @(negedge clk);
            if (prev && !sclk_o) falls++;
            prev = sclk_o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, pv;
        int lat, falls;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sclk", sclk_o, 1);
        chk("R1 irq", rx_irq_o, 0);
        rd(2'd3, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 rxbuf", v, 0);

        // vector table: R3 R4 R5 R6 R11
        for (int i = 0; i < 6; i++) begin
            logic [1:0] s;
            logic       d;
            logic [7:0] dat;
            s = VEC[i][10:9]; d = VEC[i][8]; dat = VEC[i][7:0];
            xfer(s, d, dat, -1, 0, lat, falls, pv);
            chk(d ? "R4 latency" : "R3 latency", lat, (15 + int'(d)) * divof(s));
            chk("R6 eight falling edges, R11 stays idle", falls, 8);
            rd(2'd3, v); chk("R6 done set", v, 8'h01);
            rd(2'd2, v); chk("R5 data order", v, dat);
            rd(2'd3, v); chk("R7 read clears done", v, 8'h00);
        end

        // R2: only one enable set
        wr(2'd0, 8'h01); wr(2'd1, 8'h00); idle(4);
        rd(2'd3, v); chk("R2 rx only no start", v, 8'h00);
        chk("R2 clock high", sclk_o, 1);
        wr(2'd0, 8'h02); wr(2'd1, 8'h00); idle(4);
        rd(2'd3, v); chk("R2 tx only no start", v, 8'h00);

        // R10: start write while busy
        xfer(2'd1, 1'b0, 8'h96, 30, 2, lat, falls, pv);
        chk("R10 latency unchanged", lat, 120);
        rd(2'd2, v); chk("R10 data intact", v, 8'h96);

        // R7 same-cycle read and completion
        xfer(2'd0, 1'b0, 8'h11, -1, 0, lat, falls, pv);
        xfer(2'd0, 1'b0, 8'h22, 14, 1, lat, falls, pv);
        chk("R7 read returns previous byte", pv, 8'h11);
        rd(2'd3, v); chk("R7 completion wins, no overrun", v, 8'h01);

        // R8 overrun
        xfer(2'd0, 1'b0, 8'h33, -1, 0, lat, falls, pv);
        rd(2'd3, v); chk("R8 overrun set", v, 8'h03);
        wr(2'd3, 8'h02); idle(1);
        rd(2'd3, v); chk("R8 overrun cleared", v, 8'h01);
        rd(2'd2, v); chk("R8 buffer overwritten", v, 8'h33);

        // R9 fault
        wr(2'd0, 8'h07); wr(2'd1, 8'h00); idle(20);
        irq_seen = 0;
        ssel_n_i = 1'b0;
        @(negedge clk);
        ssel_n_i = 1'b1;
        rd(2'd3, v); chk("R9 fault set and aborted", v, 8'h04);
        chk("R9 clock high", sclk_o, 1);
        idle(200);
        chk("R9 no irq after abort", irq_seen, 0);
        wr(2'd1, 8'h00); idle(4);
        rd(2'd3, v); chk("R9 start refused", v, 8'h04);
        wr(2'd3, 8'h04); idle(1);
        rd(2'd3, v); chk("R9 fault cleared", v, 8'h00);
        xfer(2'd0, 1'b1, 8'h4D, -1, 0, lat, falls, pv);
        chk("R9 transfer after clear", lat, 16);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(negedge clk) if (rx_irq_o) irq_seen++;

endmodule